// File: doc/BRIEF.md
# Bus-Mapped GPIO Bank with Pin Interrupts

This block is a general-purpose I/O bank for up to 31 pins, reached through a simple 32-bit register bus with a byte address, a write strobe, write data and registered read data. Software sets the direction of each pin. It raises or lowers output pins only through a write-one-to-set port and a write-one-to-clear port, so a write to one pin never has to read and rewrite the others. It reads the pin levels after a two-flop synchronizer.

Each pin also has an interrupt stage. An enable bit lets the pin raise its pending bit. A type bit selects level or single-edge detection. A polarity bit selects high/rising or low/falling. A mask bit decides whether a pending pin reaches the single interrupt line. Edge-captured pending bits stay set until software writes a 1 to them. A parameter chooses whether a 1 in the direction register means output or input. Pads and tristate buffers sit outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, pin_out, irq and every readable register are zero, and pin_oe is zero. In the variant where a direction 1 means input, the direction register resets to all ones so that the pins still start as inputs.
- R2: Writing offset 0x0C sets the output latch bits where the data has a 1 and leaves the others unchanged. Reading 0x0C returns the output latch.
- R3: Writing offset 0x10 clears the output latch bits where the data has a 1 and leaves the others unchanged. Reading 0x10 also returns the output latch.
- R4: Offset 0x00 is a read/write direction register. pin_oe equals it when DIR_ONE_IS_OUT=1 and equals its inverse when DIR_ONE_IS_OUT=0.
- R5: Offset 0x04 returns the pin levels two clocks after they are sampled. Writes to 0x04 are ignored.
- R6: With type bit 0 (edge mode, offset 0x18), polarity bit 1 (offset 0x1C) captures a rising edge and polarity bit 0 captures a falling edge. A captured edge sets a sticky pending bit at offset 0x20.
- R7: Writing a 1 to a pending bit of an edge-mode pin clears it. Writing to a level-mode pending bit has no effect.
- R8: With type bit 1 (level mode), the pending bit equals enable AND (pin level equals polarity bit) and follows the pin.
- R9: A pin whose enable bit (offset 0x14) is 0 never raises its pending bit, whatever the pin does.
- R10: irq is the OR over all pins of (pending AND mask), with mask at offset 0x24, and is registered one clock after the pending state.
- R11: Register bits at and above NPINS read as zero and ignore writes. Unmapped offsets read as zero, and writes to them change nothing.
- R12: Read data is registered: bus_rdata shows the register selected by bus_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Output latch to the pads |
| pin_oe | output | NPINS | Output enable per pin, 1 drives the pad |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a pending bit that outlives its cause. Examples are an edge-mode bit still set after the pin has returned, after its enable was dropped or after its type was switched, and a level-mode bit that survives a write-one-to-clear. The bench reaches these states with long runs of random writes to enable, type, polarity, mask and pending. These writes are interleaved with random pin changes, and every step is followed by a full read-back against a model. Directed steps first walk one pin through each mode, capture an edge on a disabled pin, and try to clear a held level bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Byte offsets of the register window
  localparam int GP_OFS_DIR  = 'h00;
  localparam int GP_OFS_IN   = 'h04;
  localparam int GP_OFS_SET  = 'h0C;
  localparam int GP_OFS_CLR  = 'h10;
  localparam int GP_OFS_IEN  = 'h14;
  localparam int GP_OFS_ITYP = 'h18;
  localparam int GP_OFS_IPOL = 'h1C;
  localparam int GP_OFS_IPND = 'h20;
  localparam int GP_OFS_IMSK = 'h24;
  localparam int GP_DATA_W   = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= d;
      lvl    <= meta_q;
      prev   <= lvl;
    end
  end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int W              = 16,
  parameter bit DIR_ONE_IS_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dir,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe
);
  // Direction resets to the value that makes every pin an input
  localparam logic [W-1:0] DIR_RST = DIR_ONE_IS_OUT ? '0 : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RST;
      out_q <= '0;
      oe    <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_set)      out_q <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
      if (wr_dir) oe <= DIR_ONE_IS_OUT ? wdata : ~wdata;
      else        oe <= DIR_ONE_IS_OUT ? dir_q : ~dir_q;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prev,
  input  logic         wr_en,
  input  logic         wr_typ,
  input  logic         wr_pol,
  input  logic         wr_msk,
  input  logic         wr_pnd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] typ_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] pnd_q,
  output logic         irq
);
  logic [W-1:0] pnd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      typ_q <= '0;
      pol_q <= '0;
      msk_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wdata;
      if (wr_typ) typ_q <= wdata;
      if (wr_pol) pol_q <= wdata;
      if (wr_msk) msk_q <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit_lvl, edge_seen, sw_clr;
    assign hit_lvl   = en_q[i] & (lvl[i] == pol_q[i]);
    assign edge_seen = pol_q[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]);
    assign sw_clr    = wr_pnd & wdata[i];
    assign pnd_n[i]  = typ_q[i] ? hit_lvl
                                : ((pnd_q[i] & ~sw_clr) | (en_q[i] & edge_seen));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pnd_q <= '0;
      irq   <= 1'b0;
    end else begin
      pnd_q <= pnd_n;
      irq   <= |(pnd_q & msk_q);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS          = 16,
  parameter int ADDR_W         = 8,
  parameter bit DIR_ONE_IS_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [GP_DATA_W-1:0] bus_wdata,
  output logic [GP_DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic                 irq
);
  localparam int PAD_W = GP_DATA_W - NPINS;

  logic [NPINS-1:0] wd, lvl, prev, dir_q;
  logic [NPINS-1:0] irq_en, irq_typ, irq_pol, irq_mask, irq_pend;
  logic             unused_hi;
  logic             hit_dir, hit_set, hit_clr, hit_en, hit_typ, hit_pol, hit_msk, hit_pnd;
  logic [NPINS-1:0] rd_n;

  assign wd        = bus_wdata[NPINS-1:0];
  assign unused_hi = ^bus_wdata[GP_DATA_W-1:NPINS];

  assign hit_dir = bus_we && (bus_addr == ADDR_W'(GP_OFS_DIR));
  assign hit_set = bus_we && (bus_addr == ADDR_W'(GP_OFS_SET));
  assign hit_clr = bus_we && (bus_addr == ADDR_W'(GP_OFS_CLR));
  assign hit_en  = bus_we && (bus_addr == ADDR_W'(GP_OFS_IEN));
  assign hit_typ = bus_we && (bus_addr == ADDR_W'(GP_OFS_ITYP));
  assign hit_pol = bus_we && (bus_addr == ADDR_W'(GP_OFS_IPOL));
  assign hit_msk = bus_we && (bus_addr == ADDR_W'(GP_OFS_IMSK));
  assign hit_pnd = bus_we && (bus_addr == ADDR_W'(GP_OFS_IPND));

  gpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .lvl(lvl), .prev(prev)
  );

  gpio_out_bank #(.W(NPINS), .DIR_ONE_IS_OUT(DIR_ONE_IS_OUT)) out_i (
    .clk(clk), .rst(rst),
    .wr_dir(hit_dir), .wr_set(hit_set), .wr_clr(hit_clr), .wdata(wd),
    .dir_q(dir_q), .out_q(pin_out), .oe(pin_oe)
  );

  gpio_irq_unit #(.W(NPINS)) irq_i (
    .clk(clk), .rst(rst), .lvl(lvl), .prev(prev),
    .wr_en(hit_en), .wr_typ(hit_typ), .wr_pol(hit_pol),
    .wr_msk(hit_msk), .wr_pnd(hit_pnd), .wdata(wd),
    .en_q(irq_en), .typ_q(irq_typ), .pol_q(irq_pol),
    .msk_q(irq_mask), .pnd_q(irq_pend), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(GP_OFS_DIR):  rd_n = dir_q;
      ADDR_W'(GP_OFS_IN):   rd_n = lvl;
      ADDR_W'(GP_OFS_SET):  rd_n = pin_out;
      ADDR_W'(GP_OFS_CLR):  rd_n = pin_out;
      ADDR_W'(GP_OFS_IEN):  rd_n = irq_en;
      ADDR_W'(GP_OFS_ITYP): rd_n = irq_typ;
      ADDR_W'(GP_OFS_IPOL): rd_n = irq_pol;
      ADDR_W'(GP_OFS_IPND): rd_n = irq_pend;
      ADDR_W'(GP_OFS_IMSK): rd_n = irq_mask;
      default:              rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= {{PAD_W{1'b0}}, rd_n};
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [GP_DATA_W-1:0] bus_wdata,
  input logic [GP_DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]     pin_out,
  input logic                 irq,
  input logic [NPINS-1:0]     irq_en,
  input logic [NPINS-1:0]     irq_pend,
  input logic [NPINS-1:0]     irq_mask
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && !irq && bus_rdata == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(GP_OFS_SET)) |=>
      (pin_out == ($past(pin_out) | $past(bus_wdata[NPINS-1:0]))));

  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(GP_OFS_CLR)) |=>
      (pin_out == ($past(pin_out) & ~$past(bus_wdata[NPINS-1:0]))));

  for (genvar i = 0; i < NPINS; i++) begin : g_en
    p_no_raise_r9: assert property (@(posedge clk) disable iff (rst)
      (!irq_pend[i] && !irq_en[i]) |=> !irq_pend[i]);
  end

  p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
    (|(irq_pend & irq_mask)) |=> irq);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !(|(irq_pend & irq_mask)) |=> !irq);

  p_hi_zero_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[GP_DATA_W-1:NPINS] == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq),
  .irq_en(irq_en), .irq_pend(irq_pend), .irq_mask(irq_mask)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  localparam int NP = 16;
  localparam logic [31:0] PM = 32'h0000_FFFF;
  localparam logic [7:0] A_DIR = 8'h00, A_IN = 8'h04, A_SET = 8'h0C, A_CLR = 8'h10,
                         A_IEN = 8'h14, A_TYP = 8'h18, A_POL = 8'h1C, A_PND = 8'h20,
                         A_MSK = 8'h24, A_HOLE = 8'h08, A_FAR = 8'h28;

  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, rdata_a, rdata_b;
  logic [NP-1:0] pin_in = '0, out_a, oe_a, out_b, oe_b;
  logic irq_a, irq_b;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_dir, m_dir_inv, m_out, m_en, m_typ, m_pol, m_msk, m_pnd, m_lvl;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(8), .DIR_ONE_IS_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_a), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(8), .DIR_ONE_IS_OUT(1'b0)) dut_inv_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_b), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] relevel(input logic [31:0] p);
    return ((p & ~m_typ) | (m_typ & m_en & ~(m_lvl ^ m_pol))) & PM;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    case (a)
      A_DIR: begin m_dir = d & PM; m_dir_inv = d & PM; end
      A_SET: m_out = (m_out | d) & PM;
      A_CLR: m_out = m_out & ~d & PM;
      A_IEN: m_en  = d & PM;
      A_TYP: m_typ = d & PM;
      A_POL: m_pol = d & PM;
      A_MSK: m_msk = d & PM;
      A_PND: m_pnd = m_pnd & ~(d & ~m_typ) & PM;
      default: ;
    endcase
    m_pnd = relevel(m_pnd);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = rdata_a;
  endtask

  task automatic set_pins(input logic [31:0] v);
    logic [31:0] nv, ev;
    nv = v & PM;
    ev = (m_pol & nv & ~m_lvl) | (~m_pol & ~nv & m_lvl);
    m_pnd = m_pnd | (ev & m_en & ~m_typ & PM);
    m_lvl = nv;
    m_pnd = relevel(m_pnd);
    @(negedge clk);
    pin_in = nv[NP-1:0];
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(A_DIR, v);  check({tag, " R4 dir"}, v, m_dir);
    rd(A_IN, v);   check({tag, " R5 in"}, v, m_lvl);
    rd(A_SET, v);  check({tag, " R2 set readback"}, v, m_out);
    rd(A_CLR, v);  check({tag, " R3 clr readback"}, v, m_out);
    rd(A_IEN, v);  check({tag, " R11 en"}, v, m_en);
    rd(A_TYP, v);  check({tag, " R11 type"}, v, m_typ);
    rd(A_POL, v);  check({tag, " R11 pol"}, v, m_pol);
    rd(A_MSK, v);  check({tag, " R11 mask"}, v, m_msk);
    rd(A_PND, v);  check({tag, " R6/R8 pend"}, v, m_pnd);
    rd(A_HOLE, v); check({tag, " R11 hole"}, v, 32'h0);
    rd(A_FAR, v);  check({tag, " R11 far"}, v, 32'h0);
    check({tag, " R10 irq"}, {31'h0, irq_a}, {31'h0, |(m_pnd & m_msk)});
    check({tag, " R2 pin_out"}, {16'h0, out_a}, m_out);
    check({tag, " R4 oe"}, {16'h0, oe_a}, m_dir);
    check({tag, " R4 oe inverted"}, {16'h0, oe_b}, ~m_dir_inv & PM);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    m_dir = 0; m_dir_inv = PM; m_out = 0; m_en = 0; m_typ = 0; m_pol = 0;
    m_msk = 0; m_pnd = 0; m_lvl = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 pin_out", {16'h0, out_a}, 32'h0);
    check("R1 irq", {31'h0, irq_a}, 32'h0);
    check("R1 oe", {16'h0, oe_a}, 32'h0);
    check("R1 oe inverted variant", {16'h0, oe_b}, 32'h0);
    check_all("R1");

    wr(A_DIR, 32'h0000_00FF);             check_all("R4");
    wr(A_SET, 32'hFFFF_F0F0);             check_all("R2 R11");
    wr(A_CLR, 32'h0000_3030);             check_all("R3");
    set_pins(32'h0005);                   check_all("R5");
    wr(A_IN, 32'hFFFF_FFFF);              check_all("R5 write ignored");
    wr(A_HOLE, 32'hFFFF_FFFF);            check_all("R11 hole write");

    // R12: read data lags the address by one clock
    rd(A_IN, v);
    @(negedge clk); bus_addr = A_DIR; #1;
    check("R12 before edge", rdata_a, m_lvl);
    @(negedge clk);
    check("R12 after edge", rdata_a, m_dir);

    wr(A_IEN, 32'h0000_000F);
    wr(A_TYP, 32'h0000_0004);
    wr(A_POL, 32'h0000_0005);
    wr(A_MSK, 32'h0000_0003);             check_all("R8 level hold");
    set_pins(32'h0003);                   check_all("R8 level drop");
    set_pins(32'h0000);                   check_all("R6 falling");
    set_pins(32'h0001);                   check_all("R6 rising");
    set_pins(32'h0011);                   check_all("R9 disabled pin");
    set_pins(32'h0000);                   check_all("R9 disabled fall");
    wr(A_PND, 32'h0000_0003);             check_all("R7 w1c edge");
    set_pins(32'h0004);                   check_all("R8 level high");
    wr(A_PND, 32'h0000_0004);             check_all("R7 level not cleared");
    wr(A_MSK, 32'h0000_0004);             check_all("R10 mask opens");
    wr(A_IEN, 32'h0000_0000);             check_all("R9 R8 enable off");

    for (int k = 0; k < 250; k++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 10);
      d  = $urandom();
      case (op)
        0, 1: set_pins(d);
        2: wr(A_DIR, d);
        3: wr(A_SET, d);
        4: wr(A_CLR, d);
        5: wr(A_IEN, d);
        6: wr(A_TYP, d);
        7: wr(A_POL, d);
        8: wr(A_MSK, d);
        9: wr(A_PND, d);
        default: wr((d[0] ? A_IN : A_HOLE), d);
      endcase
      check_all("random");
    end
    finish_run();
  end
endmodule